// File: doc/BRIEF.md
# Bulk-Erase Parallel Flash Command Model

This block is a synthesizable behavioural model of a byte-wide parallel flash device that is erased only as a whole. A host drives chip-select, read-strobe and write-strobe pins, an address and a data byte. The pins are sampled on a system clock, and the asserted and released strobe edges are found from one cycle to the next. Bus writes are decoded as commands by a small mode machine. Program and chip erase need a set-up byte followed by a second write, and then run on their own under an internal cycle timer against a small on-chip byte array.

While an embedded operation runs, or after one has overrun its time limit, a read returns a status byte instead of array data. Bit 7 holds the inverse of the byte being written. Bit 6 flips after every read. Bit 5 reports a time-limit failure. An identifier mode returns two fixed codes with odd parity. Reset bytes written during a set-up step back out of it without touching the array. The data path is a plain strobed bus with no valid/ready handshake: a write is taken whole on strobe release, and a read is served in the cycle it is held.

Top module: `bflash_dev`

## Requirements
- R1: A write cycle counts only while ce_n=0, oe_n=1 and we_n=0 are all sampled together. A strobe pulse taken with oe_n=0 has no effect.
- R2: The address is taken in the first cycle of a write pulse and the data byte in the cycle it ends. An address change in the middle of the pulse has no effect.
- R3: Writing 30h and then 30h again starts a chip erase. When it completes, every byte reads FFh.
- R4: Writing 10h or 50h and then an address/data write starts a program. When it completes, the byte holds old AND data.
- R5: While an operation runs, dout[7] is the inverse of bit 7 of the target byte (the program data, or FFh for erase). After completion the true array data is read.
- R6: While an operation runs, dout[6] differs between successive reads. After completion, repeated reads return identical bytes.
- R7: Chip erase first writes 00h to every byte and only then sets the array to FFh. The 00h contents are seen if the operation is cut off during its erase phase.
- R8: Two reset bytes in a row during a set-up step return to read mode, start nothing and leave the array unchanged. In erase set-up either 00h or FFh counts as a reset byte; in program set-up only FFh does. After a single reset byte, the confirming write still starts the operation.
- R9: After rst_n the model is in read mode, every array byte reads FFh and dout_en is low.
- R10: After a 90h write, address 0 reads 15h and address 1 reads B3h (each with odd parity, bit 7 being the parity bit), and other addresses read 00h. A reset byte returns to read mode.
- R11: If an operation is still running after MAX_CYC cycles it stops and dout[5] reads 1. This failed status persists until a reset byte (00h or FFh) is written or rst_n is asserted.
- R12: Writes during a running operation are ignored.
- R13: dout_en is high only while ce_n=0, oe_n=0 and we_n=1, and dout is 00h otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | sampling clock |
| rst_n | input | 1 | asynchronous active-low power-on reset |
| ce_n | input | 1 | chip select, active low |
| oe_n | input | 1 | read strobe, active low |
| we_n | input | 1 | write strobe, active low |
| addr | input | AW | byte address |
| din | input | 8 | write data byte |
| dout | output | 8 | read data or status byte |
| dout_en | output | 1 | dout is being driven |

## Verification
A wrong mode shows at the next read. A stale set-up step turns a later data write into an unexpected program, and the status byte then appears where array data was expected, within the two cycles of a read cycle. A faulty engine phase shows only once the operation ends: as a wrong byte after the programming delay, or as bytes left at 00h after an erase. The status bits are therefore read both inside the busy window and after it. A cut-off erase on a second instance makes the pre-program step visible.

// File: rtl/bflash_pkg.sv
package bflash_pkg;
  localparam logic [7:0] OP_ERASE  = 8'h30;
  localparam logic [7:0] OP_PROG_A = 8'h10;
  localparam logic [7:0] OP_PROG_B = 8'h50;
  localparam logic [7:0] OP_IDENT  = 8'h90;
  localparam logic [7:0] OP_RST_LO = 8'h00;
  localparam logic [7:0] OP_RST_HI = 8'hFF;

  typedef enum logic [2:0] {
    MD_READ, MD_IDENT, MD_ERS_SU, MD_ERS_AB, MD_PRG_SU, MD_PRG_AB
  } mode_e;

  typedef enum logic [1:0] {PH_IDLE, PH_PROG, PH_PRE, PH_ERASE} phase_e;

  // Bit 7 chosen so the whole byte has an odd number of ones.
  function automatic logic [7:0] odd_code(input logic [6:0] base);
    return {~(^base), base};
  endfunction
endpackage

// File: rtl/bflash_bus.sv
module bflash_bus #(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic          wr_fire,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_act,
  output logic          rd_end
);
  logic wr_act, wr_prev, rd_prev;

  assign wr_act = !ce_n && oe_n && !we_n;
  assign rd_act = !ce_n && !oe_n && we_n;
  assign rd_end = rd_prev && !rd_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
      wr_fire <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_prev <= wr_act;
      rd_prev <= rd_act;
      wr_fire <= wr_prev && !wr_act;
      if (wr_act && !wr_prev) wr_addr <= addr;
      if (wr_prev && !wr_act) wr_data <= din;
    end
  end
endmodule

// File: rtl/bflash_engine.sv
module bflash_engine
  import bflash_pkg::*;
#(
  parameter int AW        = 4,
  parameter int PROG_CYC  = 24,
  parameter int ERASE_CYC = 40,
  parameter int MAX_CYC   = 200
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go_prog,
  input  logic          go_erase,
  input  logic          clr,
  input  logic [AW-1:0] op_addr,
  input  logic [7:0]    op_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          busy,
  output logic          fail,
  output logic [7:0]    tgt
);
  localparam int DEPTH = 1 << AW;
  localparam int SPAN0 = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int SPAN  = (SPAN0 > DEPTH) ? SPAN0 : DEPTH;
  localparam int PW    = $clog2(SPAN + 1);
  localparam int EW    = $clog2(MAX_CYC + 1);

  logic [DEPTH-1:0][7:0] mem;
  phase_e                ph;
  logic [PW-1:0]         pc;
  logic [EW-1:0]         el;
  logic [AW-1:0]         tgt_a;

  assign busy    = (ph != PH_IDLE);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem   <= {DEPTH{8'hFF}};
      ph    <= PH_IDLE;
      pc    <= '0;
      el    <= '0;
      tgt_a <= '0;
      tgt   <= 8'hFF;
      fail  <= 1'b0;
    end else begin
      if (clr) fail <= 1'b0;
      if (ph == PH_IDLE) begin
        pc <= '0;
        el <= '0;
        if (go_prog) begin
          ph    <= PH_PROG;
          tgt_a <= op_addr;
          tgt   <= op_data;
        end else if (go_erase) begin
          ph  <= PH_PRE;
          tgt <= 8'hFF;
        end
      end else begin
        el <= el + 1'b1;
        if (el == EW'(MAX_CYC - 1)) begin
          ph   <= PH_IDLE;
          fail <= 1'b1;
        end else begin
          case (ph)
            PH_PROG: begin
              if (pc == PW'(PROG_CYC - 1)) begin
                mem[tgt_a] <= mem[tgt_a] & tgt;
                ph <= PH_IDLE;
              end else pc <= pc + 1'b1;
            end
            PH_PRE: begin
              mem[pc[AW-1:0]] <= 8'h00;
              if (pc == PW'(DEPTH - 1)) begin
                pc <= '0;
                ph <= PH_ERASE;
              end else pc <= pc + 1'b1;
            end
            PH_ERASE: begin
              if (pc == PW'(ERASE_CYC - 1)) begin
                mem <= {DEPTH{8'hFF}};
                ph  <= PH_IDLE;
              end else pc <= pc + 1'b1;
            end
            default: ph <= PH_IDLE;
          endcase
        end
      end
    end
  end

  // R8
  idle_mem_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !go_prog && !go_erase) |=> $stable(mem));
  // R4
  prog_clears_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_PROG) |=> ((mem & ~$past(mem)) == '0));
  // R11
  fail_from_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail) |-> $past(busy));
endmodule

// File: rtl/bflash_dev.sv
module bflash_dev
  import bflash_pkg::*;
#(
  parameter int         AW        = 4,
  parameter int         PROG_CYC  = 24,
  parameter int         ERASE_CYC = 40,
  parameter int         MAX_CYC   = 200,
  parameter logic [6:0] MFR_BASE  = 7'h15,
  parameter logic [6:0] DEV_BASE  = 7'h33
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    din,
  output logic [7:0]    dout,
  output logic          dout_en
);
  localparam logic [7:0] MFR_CODE = odd_code(MFR_BASE);
  localparam logic [7:0] DEV_CODE = odd_code(DEV_BASE);

  logic          wr_fire, rd_end;
  logic [AW-1:0] wr_addr;
  logic [7:0]    wr_data, rd_data, tgt, dout_v;
  logic          eng_busy, eng_fail, tog;
  logic          is_rst, take, go_prog, go_erase, clr;
  mode_e         mode;

  bflash_bus #(.AW(AW)) u_bus (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .wr_fire(wr_fire), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_act(dout_en), .rd_end(rd_end)
  );

  bflash_engine #(
    .AW(AW), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .MAX_CYC(MAX_CYC)
  ) u_eng (
    .clk(clk), .rst_n(rst_n), .go_prog(go_prog), .go_erase(go_erase),
    .clr(clr), .op_addr(wr_addr), .op_data(wr_data), .rd_addr(addr),
    .rd_data(rd_data), .busy(eng_busy), .fail(eng_fail), .tgt(tgt)
  );

  assign is_rst   = (wr_data == OP_RST_LO) || (wr_data == OP_RST_HI);
  assign take     = wr_fire && !eng_busy && !eng_fail;
  assign go_erase = take && (mode == MD_ERS_SU || mode == MD_ERS_AB) &&
                    (wr_data == OP_ERASE);
  assign go_prog  = take && (mode == MD_PRG_SU || mode == MD_PRG_AB) &&
                    (wr_data != OP_RST_HI);
  assign clr      = wr_fire && eng_fail && is_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= MD_READ;
    end else if (take) begin
      case (mode)
        MD_READ, MD_IDENT: begin
          if (wr_data == OP_ERASE) mode <= MD_ERS_SU;
          else if (wr_data == OP_PROG_A || wr_data == OP_PROG_B) mode <= MD_PRG_SU;
          else if (wr_data == OP_IDENT) mode <= MD_IDENT;
          else if (is_rst) mode <= MD_READ;
        end
        MD_ERS_SU: mode <= is_rst ? MD_ERS_AB : MD_READ;
        MD_PRG_SU: mode <= (wr_data == OP_RST_HI) ? MD_PRG_AB : MD_READ;
        default:   mode <= MD_READ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tog <= 1'b0;
    else if (rd_end && (eng_busy || eng_fail)) tog <= ~tog;
  end

  always_comb begin
    if (eng_busy || eng_fail)
      dout_v = {~tgt[7], tog, eng_fail, 5'b0};
    else if (mode == MD_IDENT)
      dout_v = (addr == AW'(0)) ? MFR_CODE :
               (addr == AW'(1)) ? DEV_CODE : 8'h00;
    else
      dout_v = rd_data;
  end

  assign dout = dout_en ? dout_v : 8'h00;

  // R3
  start_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eng_busy) |-> $past(wr_fire));
  // R12
  busy_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (mode == MD_READ));
  // R11
  fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_fail && !wr_fire) |=> eng_fail);
endmodule

// File: tb/tb_bflash_dev.sv
module tb_bflash_dev;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_WAIT = 2'd2;

  typedef struct packed {
    logic [1:0] kind;
    logic [3:0] a;
    logic [7:0] d;
  } vec_t;

  localparam vec_t TBL [19] = '{
    '{K_RD,   4'h3, 8'hFF},  // R9 erased after reset
    '{K_WR,   4'h0, 8'h50},  // R4 set-up
    '{K_WR,   4'h3, 8'h3C},
    '{K_WAIT, 4'h0, 8'd40},
    '{K_RD,   4'h3, 8'h3C},  // R4
    '{K_WR,   4'h0, 8'h10},  // R4 other set-up byte
    '{K_WR,   4'h3, 8'hF0},
    '{K_WAIT, 4'h0, 8'd40},
    '{K_RD,   4'h3, 8'h30},  // R4 old AND data
    '{K_WR,   4'h0, 8'h90},  // R10
    '{K_RD,   4'h0, 8'h15},
    '{K_RD,   4'h1, 8'hB3},
    '{K_RD,   4'h2, 8'h00},
    '{K_WR,   4'h0, 8'hFF},  // R10 exit
    '{K_RD,   4'h0, 8'hFF},
    '{K_WR,   4'h0, 8'h30},  // R3
    '{K_WR,   4'h0, 8'h30},
    '{K_WAIT, 4'h0, 8'd80},
    '{K_RD,   4'h3, 8'hFF}   // R3
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] din = '0;
  logic [7:0] dout, dout2;
  logic dout_en, dout_en2;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bflash_dev dut (.clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en));

  bflash_dev #(.MAX_CYC(30)) dut_t (.clk(clk), .rst_n(rst_n), .ce_n(ce_n),
    .oe_n(oe_n), .we_n(we_n), .addr(addr), .din(din), .dout(dout2),
    .dout_en(dout_en2));

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; din = d; ce_n = 0; oe_n = 1; we_n = 0;
    repeat (2) @(negedge clk);
    we_n = 1; ce_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] v,
                          output logic [7:0] v2, output logic en);
    @(negedge clk);
    addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk);
    v = dout; v2 = dout2; en = dout_en;
    ce_n = 1; oe_n = 1;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, w, v2, w2;
    logic en;
    do_reset();
    // R9 / R13 idle output
    check({7'b0, dout_en}, 8'h00, "R9 dout_en idle");
    check(dout, 8'h00, "R13 dout idle");
    bus_read(4'h5, v, v2, en);
    check({7'b0, en}, 8'h01, "R13 dout_en in read");

    for (int i = 0; i < 19; i++) begin
      case (TBL[i].kind)
        K_WR:    bus_write(TBL[i].a, TBL[i].d);
        K_WAIT:  repeat (int'(TBL[i].d)) @(negedge clk);
        default: begin
          bus_read(TBL[i].a, v, v2, en);
          check(v, TBL[i].d, $sformatf("table vector %0d", i));
        end
      endcase
    end

    // R10 odd parity of identifiers
    bus_write(4'h0, 8'h90);
    bus_read(4'h0, v, v2, en);
    check({7'b0, ^v}, 8'h01, "R10 parity code 0");
    bus_read(4'h1, v, v2, en);
    check({7'b0, ^v}, 8'h01, "R10 parity code 1");
    bus_write(4'h0, 8'h00);

    // R1: strobes with oe_n low are not writes
    @(negedge clk); addr = 0; din = 8'h30; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    @(negedge clk); addr = 0; din = 8'h30; ce_n = 0; oe_n = 0; we_n = 0;
    repeat (2) @(negedge clk); we_n = 1; ce_n = 1; oe_n = 1;
    repeat (2) @(negedge clk);
    bus_read(4'h3, v, v2, en);
    check(v, 8'hFF, "R1 no erase from blocked writes");

    // R2: address moves during the pulse
    bus_write(4'h0, 8'h50);
    @(negedge clk); addr = 4'h2; din = 8'h55; ce_n = 0; oe_n = 1; we_n = 0;
    @(negedge clk); addr = 4'h7;
    @(negedge clk); we_n = 1; ce_n = 1;
    repeat (40) @(negedge clk);
    bus_read(4'h2, v, v2, en);
    check(v, 8'h55, "R2 programmed at first address");
    bus_read(4'h7, v, v2, en);
    check(v, 8'hFF, "R2 second address untouched");

    // R5 / R6 status while programming
    bus_write(4'h0, 8'h50);
    bus_write(4'h4, 8'h81);
    bus_read(4'h4, v, v2, en);
    bus_read(4'h4, w, w2, en);
    check(v & 8'h80, 8'h00, "R5 inverted bit 7 while busy");
    check((v ^ w) & 8'h40, 8'h40, "R6 bit 6 toggles while busy");
    repeat (40) @(negedge clk);
    bus_read(4'h4, v, v2, en);
    bus_read(4'h4, w, w2, en);
    check(v, 8'h81, "R5 true data after completion");
    check(w, v, "R6 no toggle after completion");

    // R12: commands during busy ignored
    bus_write(4'h0, 8'h50);
    bus_write(4'h6, 8'h0F);
    bus_write(4'h0, 8'h30);
    bus_write(4'h0, 8'h30);
    repeat (40) @(negedge clk);
    bus_read(4'h6, v, v2, en);
    check(v, 8'h0F, "R12 program result");
    bus_read(4'h2, v, v2, en);
    check(v, 8'h55, "R12 no erase from busy writes");

    // R8 aborts
    bus_write(4'h0, 8'h10);
    bus_write(4'h5, 8'hFF);
    bus_write(4'h5, 8'hFF);
    bus_read(4'h5, v, v2, en);
    check(v, 8'hFF, "R8 program set-up aborted");
    bus_write(4'h0, 8'h30);
    bus_write(4'h0, 8'h00);
    bus_write(4'h0, 8'h00);
    bus_read(4'h2, v, v2, en);
    check(v, 8'h55, "R8 erase set-up aborted");
    // R8 single reset then confirm still erases
    bus_write(4'h0, 8'h30);
    bus_write(4'h0, 8'hFF);
    bus_write(4'h0, 8'h30);
    bus_read(4'h2, v, v2, en);
    check(v & 8'h80, 8'h00, "R8 erase running after single reset");
    repeat (80) @(negedge clk);
    bus_read(4'h2, v, v2, en);
    check(v, 8'hFF, "R8 erase completed");

    // R11 / R7 on the short time-limit instance
    do_reset();
    bus_write(4'h0, 8'h30);
    bus_write(4'h0, 8'h30);
    repeat (60) @(negedge clk);
    bus_read(4'h3, v, v2, en);
    check(v2 & 8'hA0, 8'h20, "R11 failed status");
    check(v, 8'hFF, "R3 erase on full-limit instance");
    bus_read(4'h3, v, v2, en);
    check(v2 & 8'hA0, 8'h20, "R11 failed status persists");
    bus_write(4'h0, 8'hFF);
    bus_read(4'h3, v, v2, en);
    check(v2, 8'h00, "R7 pre-programmed byte after cut-off");
    check(v, 8'hFF, "R11 reset byte harmless in read mode");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule